// File: doc/BRIEF.md
# Non-Volatile Memory Command Register Front End

This block is the register side of a non-volatile memory controller. Software reaches it over a simple register bus with four word-wide locations. These are a clock-divider register, a status register, an index register and a data window. The data window opens onto a small array of parameter words, and the index register selects which word it shows. Software loads a command code and its operands into that array. It then starts the command by writing 1 to the command-complete flag.

When the launch is accepted, the block sends a one-cycle pulse to an execution engine and presents the parameter words to it. It then locks the array against software writes until the engine reports completion. While the command runs, the engine may write result words back into the array. A launch is refused if either error flag is set. If the divider has never been programmed since reset, the launch is refused and an access error is raised instead.

Top module: `nvm_cmd_regs`

## Requirements
- R1: Writing address 0 stores bits [7:0] as the divider and sets a read-only loaded flag seen at bit 15 of address 0; that flag reads 0 until the first divider write after reset and then stays 1.
- R2: Writing 1 to status bit 0 while the loaded flag is 0 (complete flag 1, error flags clear) produces no launch pulse, leaves the complete flag at 1 and sets the access-error flag (status bit 1).
- R3: A launch request is refused with no pulse and no state change when the access-error flag (bit 1) or the protection-violation flag (bit 2) is set.
- R4: While the complete flag reads 0, writes through the data window (address 3) leave the parameter words unchanged.
- R5: Address 2 holds a 3-bit index in bits [2:0]; reads and writes of address 3 reach the parameter word that index selects.
- R6: An accepted launch raises `eng_launch` for exactly the one cycle after the write, and the complete flag reads 0 from that cycle until the cycle after `eng_done` is seen.
- R7: Writing 1 to status bit 0 while the complete flag is already 0 has no effect and produces no further launch pulse.
- R8: Index values 6 and 7 select no storage: writes through them are dropped and reads through them return 0x0000.
- R9: `eng_cmd_code` equals bits [15:8] of parameter word 0, and `eng_words` carries word k in bits [16k+15:16k].
- R10: While a command is active, `eng_ret_we` writes `eng_ret_data` into the word at `eng_ret_idx` (indices 6 and 7 dropped), and software reads that value once the complete flag is back at 1.
- R11: Writing 1 to status bit 1 or bit 2 clears that flag; `eng_viol` high together with `eng_done` sets the protection-violation flag.
- R12: After reset, the divider, loaded flag, index, error flags and all parameter words are 0, and the complete flag is 1 (status reads 0x0001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 divider, 1 status, 2 index, 3 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| eng_launch | output | 1 | One-cycle command start pulse |
| eng_cmd_code | output | 8 | Command code, upper byte of word 0 |
| eng_words | output | 96 | All parameter words, word k at bits [16k+15:16k] |
| eng_done | input | 1 | Engine reports command completion |
| eng_viol | input | 1 | Protection violation reported together with `eng_done` |
| eng_ret_we | input | 1 | Engine result write strobe |
| eng_ret_idx | input | 3 | Index of the result word |
| eng_ret_data | input | 16 | Result word data |

## Verification
Directed cases go through the launch gates one at a time. They cover a launch with the divider unwritten, a launch with each error flag set, a repeat request while busy, and writes to the array during a command. Each case is told apart by whether a pulse appears and by which status bits read back. Random phases mix index and data writes across all eight index values, divider rewrites and full command cycles. In those cycles the engine returns a random word, possibly to an unimplemented slot, and raises a random violation. A bench model of the array and flags is compared against every readback, which separates correct lock and drop behaviour from leakage.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;
   localparam logic [1:0] ADR_DIV  = 2'd0;
   localparam logic [1:0] ADR_STAT = 2'd1;
   localparam logic [1:0] ADR_IDX  = 2'd2;
   localparam logic [1:0] ADR_DATA = 2'd3;

   localparam int ST_DONE_BIT = 0;
   localparam int ST_ACC_BIT  = 1;
   localparam int ST_PV_BIT   = 2;
endpackage

// File: rtl/nvm_div_reg.sv
module nvm_div_reg #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DIV_W-1:0] wdata,
   output logic [DIV_W-1:0] div_q,
   output logic             loaded_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= '0;
         loaded_q <= 1'b0;
      end else if (wr_en) begin
         div_q    <= wdata;
         loaded_q <= 1'b1;
      end
   end
endmodule

// File: rtl/nvm_launch_ctrl.sv
module nvm_launch_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic st_wr,
   input  logic wr_go,
   input  logic wr_clr_acc,
   input  logic wr_clr_pv,
   input  logic loaded,
   input  logic eng_done,
   input  logic eng_viol,
   output logic cmd_done,
   output logic acc_err,
   output logic pviol,
   output logic launch
);
   logic request, clean, accept, refuse;

   always_comb begin
      request = st_wr && wr_go && cmd_done;
      clean   = !acc_err && !pviol;
      accept  = request && clean && loaded;
      refuse  = request && clean && !loaded;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_done <= 1'b1;
         acc_err  <= 1'b0;
         pviol    <= 1'b0;
         launch   <= 1'b0;
      end else begin
         launch <= accept;
         if (accept)
            cmd_done <= 1'b0;
         else if (!cmd_done && eng_done)
            cmd_done <= 1'b1;
         if (refuse)
            acc_err <= 1'b1;
         else if (st_wr && wr_clr_acc)
            acc_err <= 1'b0;
         if (!cmd_done && eng_done && eng_viol)
            pviol <= 1'b1;
         else if (st_wr && wr_clr_pv)
            pviol <= 1'b0;
      end
   end
endmodule

// File: rtl/nvm_param_array.sv
module nvm_param_array #(
   parameter int DATA_W    = 16,
   parameter int IDX_W     = 3,
   parameter int NUM_WORDS = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        locked,
   input  logic                        user_we,
   input  logic [IDX_W-1:0]            user_idx,
   input  logic [DATA_W-1:0]           user_data,
   input  logic                        ret_we,
   input  logic [IDX_W-1:0]            ret_idx,
   input  logic [DATA_W-1:0]           ret_data,
   output logic [DATA_W-1:0]           rd_data,
   output logic [NUM_WORDS*DATA_W-1:0] words_flat
);
   localparam int SLOTS = 1 << IDX_W;

   logic [DATA_W-1:0] slot_q [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g < NUM_WORDS) begin : g_impl
         logic sel_user, sel_ret;
         always_comb begin
            sel_user = user_we && !locked && (user_idx == IDX_W'(g));
            sel_ret  = ret_we && locked && (ret_idx == IDX_W'(g));
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[g] <= '0;
            else if (sel_ret)
               slot_q[g] <= ret_data;
            else if (sel_user)
               slot_q[g] <= user_data;
         end
         assign words_flat[g*DATA_W +: DATA_W] = slot_q[g];
      end else begin : g_void
         assign slot_q[g] = '0;
      end
   end

   assign rd_data = slot_q[user_idx];
endmodule

// File: rtl/nvm_cmd_regs.sv
module nvm_cmd_regs #(
   parameter int DATA_W    = 16,
   parameter int IDX_W     = 3,
   parameter int NUM_WORDS = 6,
   parameter int DIV_W     = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic [1:0]                  bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic                        eng_launch,
   output logic [7:0]                  eng_cmd_code,
   output logic [NUM_WORDS*DATA_W-1:0] eng_words,
   input  logic                        eng_done,
   input  logic                        eng_viol,
   input  logic                        eng_ret_we,
   input  logic [IDX_W-1:0]            eng_ret_idx,
   input  logic [DATA_W-1:0]           eng_ret_data
);
   import nvm_cmd_pkg::*;

   localparam int DIV_PAD = DATA_W - 1 - DIV_W;
   localparam int IDX_PAD = DATA_W - IDX_W;

   initial begin
      if (NUM_WORDS < 1 || NUM_WORDS > (1 << IDX_W))
         $error("NUM_WORDS must fit the index range");
      if (DIV_PAD < 1)
         $error("DIV_W must leave room for the loaded flag");
      if (DATA_W < 8)
         $error("DATA_W must hold a command byte");
   end

   logic [DIV_W-1:0]  div_q;
   logic              loaded;
   logic [IDX_W-1:0]  idx_q;
   logic              cmd_done, acc_err, pviol;
   logic [DATA_W-1:0] arr_rd;
   logic              wr_div, wr_stat, wr_idx, wr_data;

   always_comb begin
      wr_div  = bus_wr && (bus_addr == ADR_DIV);
      wr_stat = bus_wr && (bus_addr == ADR_STAT);
      wr_idx  = bus_wr && (bus_addr == ADR_IDX);
      wr_data = bus_wr && (bus_addr == ADR_DATA);
   end

   nvm_div_reg #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_div),
      .wdata    (bus_wdata[DIV_W-1:0]),
      .div_q    (div_q),
      .loaded_q (loaded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (wr_idx)
         idx_q <= bus_wdata[IDX_W-1:0];
   end

   nvm_launch_ctrl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_wr      (wr_stat),
      .wr_go      (bus_wdata[ST_DONE_BIT]),
      .wr_clr_acc (bus_wdata[ST_ACC_BIT]),
      .wr_clr_pv  (bus_wdata[ST_PV_BIT]),
      .loaded     (loaded),
      .eng_done   (eng_done),
      .eng_viol   (eng_viol),
      .cmd_done   (cmd_done),
      .acc_err    (acc_err),
      .pviol      (pviol),
      .launch     (eng_launch)
   );

   nvm_param_array #(
      .DATA_W    (DATA_W),
      .IDX_W     (IDX_W),
      .NUM_WORDS (NUM_WORDS)
   ) u_arr (
      .clk        (clk),
      .rst_n      (rst_n),
      .locked     (!cmd_done),
      .user_we    (wr_data),
      .user_idx   (idx_q),
      .user_data  (bus_wdata),
      .ret_we     (eng_ret_we),
      .ret_idx    (eng_ret_idx),
      .ret_data   (eng_ret_data),
      .rd_data    (arr_rd),
      .words_flat (eng_words)
   );

   assign eng_cmd_code = eng_words[DATA_W-1 -: 8];

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_DIV:  bus_rdata = {loaded, {DIV_PAD{1'b0}}, div_q};
         ADR_STAT: begin
            bus_rdata[ST_DONE_BIT] = cmd_done;
            bus_rdata[ST_ACC_BIT]  = acc_err;
            bus_rdata[ST_PV_BIT]   = pviol;
         end
         ADR_IDX:  bus_rdata = {{IDX_PAD{1'b0}}, idx_q};
         default:  bus_rdata = arr_rd;
      endcase
   end
endmodule

// File: rtl/nvm_cmd_chk.sv
module nvm_cmd_chk #(
   parameter int DATA_W  = 16,
   parameter int WORDS_W = 96
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [1:0]         bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic               eng_launch,
   input logic               eng_done,
   input logic               eng_ret_we,
   input logic               cmd_done,
   input logic               acc_err,
   input logic               pviol,
   input logic               loaded,
   input logic [WORDS_W-1:0] eng_words
);
   import nvm_cmd_pkg::*;

   logic go_wr;
   assign go_wr = bus_wr && (bus_addr == ADR_STAT) && bus_wdata[ST_DONE_BIT];

   a_r1_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      loaded |=> loaded);

   a_r2_unloaded_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (go_wr && cmd_done && !acc_err && !pviol && !loaded) |=> (acc_err && !eng_launch && cmd_done));

   a_r3_launch_clean: assert property (@(posedge clk) disable iff (!rst_n)
      eng_launch |-> (!acc_err && !pviol && loaded));

   a_r4_words_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_done && !eng_ret_we) |=> $stable(eng_words));

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eng_launch |=> !eng_launch);

   a_r6_busy_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
      eng_launch |-> !cmd_done);

   a_r6_done_from_engine: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_done) |-> $past(eng_done));

   a_r7_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
      (go_wr && !cmd_done) |=> !eng_launch);
endmodule

bind nvm_cmd_regs nvm_cmd_chk #(
   .DATA_W  (DATA_W),
   .WORDS_W (NUM_WORDS*DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .eng_launch (eng_launch),
   .eng_done   (eng_done),
   .eng_ret_we (eng_ret_we),
   .cmd_done   (cmd_done),
   .acc_err    (acc_err),
   .pviol      (pviol),
   .loaded     (loaded),
   .eng_words  (eng_words)
);

// File: tb/tb_nvm_cmd_regs.sv
module tb_nvm_cmd_regs;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        eng_launch;
   logic [7:0]  eng_cmd_code;
   logic [95:0] eng_words;
   logic        eng_done = 1'b0;
   logic        eng_viol = 1'b0;
   logic        eng_ret_we = 1'b0;
   logic [2:0]  eng_ret_idx = 3'd0;
   logic [15:0] eng_ret_data = 16'h0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [15:0] m_w [8];
   logic [2:0]  m_idx;
   logic [7:0]  m_div;
   logic        m_ld, m_done, m_acc, m_pv;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvm_cmd_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_launch(eng_launch),
      .eng_cmd_code(eng_cmd_code), .eng_words(eng_words), .eng_done(eng_done),
      .eng_viol(eng_viol), .eng_ret_we(eng_ret_we), .eng_ret_idx(eng_ret_idx),
      .eng_ret_data(eng_ret_data)
   );

   function automatic logic [15:0] exp_stat();
      return {13'h0, m_pv, m_acc, m_done};
   endfunction

   function automatic logic [15:0] exp_data();
      return (m_idx < 3'd6) ? m_w[m_idx] : 16'h0;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 2'd0) begin m_div = d[7:0]; m_ld = 1'b1; end
      if (a == 2'd2) m_idx = d[2:0];
      if (a == 2'd3 && m_done && m_idx < 3'd6) m_w[m_idx] = d;
      if (a == 2'd1) begin
         if (d[1]) m_acc = 1'b0;
         if (d[2]) m_pv = 1'b0;
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic ret(input logic [2:0] i, input logic [15:0] d);
      eng_ret_we = 1'b1; eng_ret_idx = i; eng_ret_data = d;
      @(negedge clk);
      eng_ret_we = 1'b0;
      if (i < 3'd6) m_w[i] = d;
   endtask

   task automatic finish_cmd(input logic v);
      eng_done = 1'b1; eng_viol = v;
      @(negedge clk);
      eng_done = 1'b0; eng_viol = 1'b0;
      m_done = 1'b1;
      if (v) m_pv = 1'b1;
   endtask

   // request launch; model decides acceptance, then pulse is checked
   task automatic go(input string req, output logic took);
      logic ok;
      ok = m_done && !m_acc && !m_pv && m_ld;
      if (m_done && !m_acc && !m_pv && !m_ld) m_acc = 1'b1;
      bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0001;
      @(negedge clk);
      bus_wr = 1'b0;
      chk({req, " launch pulse"}, {15'h0, eng_launch}, {15'h0, ok});
      if (ok) begin
         m_done = 1'b0;
         chk("R9 cmd code", {8'h0, eng_cmd_code}, {8'h0, m_w[0][15:8]});
      end
      took = ok;
      @(negedge clk);
      chk({req, " pulse one cycle"}, {15'h0, eng_launch}, 16'h0);
   endtask

   task automatic chk_words(input string req);
      for (int k = 0; k < 6; k++)
         chk(req, eng_words[k*16 +: 16], m_w[k]);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] v;
      logic took;
      void'($urandom(32'd4242));
      for (int k = 0; k < 8; k++) m_w[k] = 16'h0;
      m_idx = 3'd0; m_div = 8'h0; m_ld = 1'b0; m_done = 1'b1; m_acc = 1'b0; m_pv = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      rd(2'd1, v); chk("R12 status", v, 16'h0001);
      rd(2'd0, v); chk("R12 divider", v, 16'h0000);
      rd(2'd2, v); chk("R12 index", v, 16'h0000);
      chk_words("R12 words");

      // R2 launch before divider write
      go("R2", took);
      rd(2'd1, v); chk("R2 acc err set", v, 16'h0003);

      // R3 refused while acc err set even after divider loaded
      wr(2'd0, 16'h0025);
      rd(2'd0, v); chk("R1 divider loaded", v, 16'h8025);
      go("R3 acc", took);
      rd(2'd1, v); chk("R3 status kept", v, 16'h0003);
      wr(2'd1, 16'h0002);
      rd(2'd1, v); chk("R11 w1c acc", v, 16'h0001);
      wr(2'd0, 16'h0011);
      rd(2'd0, v); chk("R1 rewrite keeps flag", v, 16'h8011);

      // R5 index/data, R8 unimplemented slots
      for (int k = 0; k < 8; k++) begin
         wr(2'd2, 16'(k));
         wr(2'd3, 16'hA100 + 16'(k));
      end
      for (int k = 0; k < 8; k++) begin
         wr(2'd2, 16'(k));
         rd(2'd3, v);
         chk(k < 6 ? "R5 word readback" : "R8 void slot", v, exp_data());
      end
      chk_words("R9 word layout");

      // R6 launch, R4 lock, R7 relaunch, R10 result
      wr(2'd2, 16'd0); wr(2'd3, 16'h5A07);
      go("R6", took);
      rd(2'd1, v); chk("R6 busy status", v, 16'h0000);
      wr(2'd3, 16'hDEAD);
      wr(2'd2, 16'd3); wr(2'd3, 16'hBEEF);
      chk_words("R4 locked words");
      go("R7", took);
      ret(3'd3, 16'h1234);
      ret(3'd7, 16'h4321);
      rd(2'd1, v); chk("R6 still busy", v, 16'h0000);
      finish_cmd(1'b0);
      rd(2'd1, v); chk("R6 done back", v, 16'h0001);
      rd(2'd3, v); chk("R10 result word", v, 16'h1234);
      wr(2'd2, 16'd7);
      rd(2'd3, v); chk("R8 ret void", v, 16'h0000);

      // R11 violation then R3 refusal
      go("R6 second", took);
      finish_cmd(1'b1);
      rd(2'd1, v); chk("R11 pviol set", v, 16'h0005);
      go("R3 pv", took);
      rd(2'd1, v); chk("R3 pv kept", v, 16'h0005);
      wr(2'd1, 16'h0004);
      rd(2'd1, v); chk("R11 w1c pv", v, 16'h0001);

      // random phase
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom_range(0, 5));
         case (op)
            0: wr(2'd2, 16'($urandom));
            1: wr(2'd3, 16'($urandom));
            2: begin rd(2'd3, v); chk("R5 random read", v, exp_data()); end
            3: begin wr(2'd0, 16'($urandom)); rd(2'd0, v); chk("R1 random div", v, {8'h80, m_div}); end
            4: begin
               go("R6 random", took);
               if (took) begin
                  repeat ($urandom_range(0, 3)) begin
                     if ($urandom_range(0, 1) == 1) wr(2'd3, 16'($urandom));
                     else ret(3'($urandom), 16'($urandom));
                  end
                  chk_words("R4 random lock");
                  finish_cmd(1'($urandom_range(0, 1)));
               end
               rd(2'd1, v); chk("R11 random status", v, exp_stat());
            end
            default: begin
               wr(2'd1, {13'h0, 3'($urandom) & 3'b110});
               rd(2'd1, v); chk("R11 random clear", v, exp_stat());
            end
         endcase
      end
      chk_words("R10 final words");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule